// File: doc/BRIEF.md
# Tiled Matrix Multiply Schedule Controller

This controller sequences a fixed N×N weight-stationary multiply array through products whose operands are larger than the array. Both operand matrices are cut into N×N tiles. The weight tile is the outer loop. For each weight tile the controller first runs a weight-load phase. It then streams every activation tile through the array while partial sums build up. It waits out the array's pipeline fill and drain. Only then does it ask for the accumulated results to be written back, after which it moves to the next weight tile.

The numbers of weight tiles and activation tiles are given at run time. Both are captured when a start pulse is taken. The controller drives one strobe per phase, the current weight and activation tile indices, and a one-cycle completion flag. It advances a phase only on the handshake that belongs to it: the array reports a finished weight load or a finished activation tile, and the memory side reports a finished write-back. The drain phase is a fixed wait of 2N−1 cycles and needs no handshake.

Top module: `tile_sched_ctrl`

## Requirements
- R1: After reset every phase strobe and `done_o` are low and both tile indices are zero.
- R2: A `start_i` pulse taken while idle with both counts nonzero enters the weight-load phase in the next cycle, with both indices at zero. The counts are captured at that point. Later changes to the count inputs, and `start_i` pulses during a job, have no effect until the job ends.
- R3: `w_load_o` stays high, with unchanged indices, until `w_ready_i` is seen. The next cycle starts streaming with the activation index at zero.
- R4: While `a_stream_o` is high, each `a_done_i` advances the activation index by one. The `a_done_i` taken at index count−1 moves to the drain phase instead, so the index runs from 0 to count−1 in order.
- R5: `drain_o` stays high for exactly 2N−1 consecutive cycles, and write-back follows directly.
- R6: `wb_o` stays high until `wb_done_i` is seen. If weight tiles remain, the weight index then steps by one and the activation index returns to zero in a new weight-load phase.
- R7: After the write-back of the last weight tile, `done_o` is high for exactly one cycle, with no other strobe, and the controller is then idle. During that cycle the weight index shows the last tile and the activation index shows zero.
- R8: A start taken with either count equal to zero goes straight to the one-cycle `done_o`, with both indices zero and no other phase.
- R9: At most one of the five phase strobes is high in any cycle. A handshake input that arrives outside its own phase, or while idle, changes neither a strobe nor an index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job (taken only while idle) |
| n_wtile_i | input | CNT_W | Number of weight tiles |
| n_atile_i | input | CNT_W | Number of activation tiles per weight tile |
| w_ready_i | input | 1 | Array has finished loading the weight tile |
| a_done_i | input | 1 | Array has finished taking the current activation tile |
| wb_done_i | input | 1 | Memory side has finished writing back the results |
| w_load_o | output | 1 | Weight-load phase strobe |
| a_stream_o | output | 1 | Activation streaming phase strobe |
| drain_o | output | 1 | Pipeline drain wait strobe |
| wb_o | output | 1 | Write-back phase strobe |
| done_o | output | 1 | One-cycle job completion flag |
| wt_idx_o | output | CNT_W | Current weight tile index |
| at_idx_o | output | CNT_W | Current activation tile index |

## Verification
The bench builds the controller with ARRAY_N = 3 and CNT_W = 4. This gives a drain of five cycles, short enough to time exactly on every pass. It also puts the largest count, 15, within reach, so a job can run the activation index to its top value of 14. Handshake delays are varied per job, including handshakes held high throughout. That covers both single-cycle phase turnarounds and the case where handshakes from other phases are present during a weight load.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOAD   = 3'd1,
    PH_STREAM = 3'd2,
    PH_DRAIN  = 3'd3,
    PH_WB     = 3'd4,
    PH_DONE   = 3'd5
  } phase_e;
endpackage

// File: rtl/tsc_idx_cnt.sv
module tsc_idx_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] idx_o,
  output logic         last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (clr_i) idx_o <= '0;
    else if (inc_i) idx_o <= idx_o + W'(1);
  end

  assign last_o = (idx_o == limit_i - W'(1));
endmodule

// File: rtl/tsc_drain_timer.sv
module tsc_drain_timer #(
  parameter int ARRAY_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expire_o
);
  localparam int DRAIN_CYC = 2 * ARRAY_N - 1;
  localparam int TW        = $clog2(2 * ARRAY_N);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + TW'(1);
  end

  assign expire_o = en_i && (cnt_q == TW'(DRAIN_CYC - 1));
endmodule

// File: rtl/tsc_fsm.sv
module tsc_fsm
  import tsc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   zero_cnt_i,
  input  logic   w_ready_i,
  input  logic   a_done_i,
  input  logic   wb_done_i,
  input  logic   at_last_i,
  input  logic   wt_last_i,
  input  logic   drain_exp_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start_i)                phase_d = zero_cnt_i ? PH_DONE : PH_LOAD;
      PH_LOAD:   if (w_ready_i)              phase_d = PH_STREAM;
      PH_STREAM: if (a_done_i && at_last_i)  phase_d = PH_DRAIN;
      PH_DRAIN:  if (drain_exp_i)            phase_d = PH_WB;
      PH_WB:     if (wb_done_i)              phase_d = wt_last_i ? PH_DONE : PH_LOAD;
      PH_DONE:                               phase_d = PH_IDLE;
      default:                               phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/tile_sched_ctrl.sv
module tile_sched_ctrl
  import tsc_pkg::*;
#(
  parameter int ARRAY_N = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_wtile_i,
  input  logic [CNT_W-1:0] n_atile_i,
  input  logic             w_ready_i,
  input  logic             a_done_i,
  input  logic             wb_done_i,
  output logic             w_load_o,
  output logic             a_stream_o,
  output logic             drain_o,
  output logic             wb_o,
  output logic             done_o,
  output logic [CNT_W-1:0] wt_idx_o,
  output logic [CNT_W-1:0] at_idx_o
);
  localparam int NCNT = 2;  // 0: weight tiles, 1: activation tiles

  phase_e           phase;
  logic [CNT_W-1:0] n_w_q, n_a_q;
  logic             take_start, zero_cnt, wb_fin;
  logic             drain_exp;
  logic [NCNT-1:0]  c_clr, c_inc, c_last;
  logic [CNT_W-1:0] c_lim [NCNT];
  logic [CNT_W-1:0] c_idx [NCNT];

  assign take_start = (phase == PH_IDLE) && start_i;
  assign zero_cnt   = (n_wtile_i == '0) || (n_atile_i == '0);
  assign wb_fin     = (phase == PH_WB) && wb_done_i;

  // counts are frozen for the whole job
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_w_q <= '0;
      n_a_q <= '0;
    end else if (take_start) begin
      n_w_q <= n_wtile_i;
      n_a_q <= n_atile_i;
    end
  end

  assign c_lim[0] = n_w_q;
  assign c_lim[1] = n_a_q;
  assign c_clr[0] = take_start;
  assign c_clr[1] = take_start || wb_fin;
  assign c_inc[0] = wb_fin && !c_last[0];
  assign c_inc[1] = (phase == PH_STREAM) && a_done_i && !c_last[1];

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    tsc_idx_cnt #(.W(CNT_W)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (c_clr[g]),
      .inc_i   (c_inc[g]),
      .limit_i (c_lim[g]),
      .idx_o   (c_idx[g]),
      .last_o  (c_last[g])
    );
  end

  tsc_drain_timer #(.ARRAY_N(ARRAY_N)) i_drain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (phase == PH_DRAIN),
    .expire_o (drain_exp)
  );

  tsc_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .zero_cnt_i  (zero_cnt),
    .w_ready_i   (w_ready_i),
    .a_done_i    (a_done_i),
    .wb_done_i   (wb_done_i),
    .at_last_i   (c_last[1]),
    .wt_last_i   (c_last[0]),
    .drain_exp_i (drain_exp),
    .phase_o     (phase)
  );

  assign w_load_o   = (phase == PH_LOAD);
  assign a_stream_o = (phase == PH_STREAM);
  assign drain_o    = (phase == PH_DRAIN);
  assign wb_o       = (phase == PH_WB);
  assign done_o     = (phase == PH_DONE);
  assign wt_idx_o   = c_idx[0];
  assign at_idx_o   = c_idx[1];
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
  parameter int ARRAY_N = 4,
  parameter int CNT_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             w_ready_i,
  input logic             a_done_i,
  input logic             wb_done_i,
  input logic             w_load_o,
  input logic             a_stream_o,
  input logic             drain_o,
  input logic             wb_o,
  input logic             done_o,
  input logic [CNT_W-1:0] wt_idx_o,
  input logic [CNT_W-1:0] at_idx_o
);
  localparam int DRAIN_CYC = 2 * ARRAY_N - 1;

  logic [15:0] dcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dcnt <= '0;
    else if (drain_o) dcnt <= dcnt + 16'd1;
    else              dcnt <= '0;
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({w_load_o, a_stream_o, drain_o, wb_o, done_o}));
  // R3
  load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_load_o && !w_ready_i |=> w_load_o && $stable(wt_idx_o) && $stable(at_idx_o));
  // R4
  stream_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_stream_o && !a_done_i |=> a_stream_o && $stable(at_idx_o));
  // R4
  stream_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_stream_o && a_done_i |=> drain_o || (a_stream_o && at_idx_o == $past(at_idx_o) + CNT_W'(1)));
  // R5
  drain_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drain_o) |-> wb_o && dcnt == 16'(DRAIN_CYC));
  // R6
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o && !wb_done_i |=> wb_o && $stable(wt_idx_o));
  // R6
  wb_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_o) |-> $past(drain_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !w_load_o && !a_stream_o && !drain_o && !wb_o);
endmodule

bind tile_sched_ctrl tsc_chk #(.ARRAY_N(ARRAY_N), .CNT_W(CNT_W)) i_tsc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .w_ready_i  (w_ready_i),
  .a_done_i   (a_done_i),
  .wb_done_i  (wb_done_i),
  .w_load_o   (w_load_o),
  .a_stream_o (a_stream_o),
  .drain_o    (drain_o),
  .wb_o       (wb_o),
  .done_o     (done_o),
  .wt_idx_o   (wt_idx_o),
  .at_idx_o   (at_idx_o)
);

// File: tb/test_tile_sched_ctrl.sv
`timescale 1ns/1ps
module test_tile_sched_ctrl;
  localparam int ARRAY_N   = 3;
  localparam int CNT_W     = 4;
  localparam int DRAIN_CYC = 2 * ARRAY_N - 1;
  localparam int WDOG      = 100000;
  localparam int IW        = 3 + 2 * CNT_W;

  // phase codes used by the bench only
  localparam int C_IDLE = 0, C_LOAD = 1, C_STR = 2, C_DRN = 3, C_WB = 4, C_DONE = 5, C_BAD = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] n_w = '0, n_a = '0;
  logic w_ready, a_done, wb_done;
  logic w_load, a_stream, drain, wb, done;
  logic [CNT_W-1:0] wt_idx, at_idx;

  always #2.5 clk = ~clk;

  tile_sched_ctrl #(.ARRAY_N(ARRAY_N), .CNT_W(CNT_W)) i_tile_sched_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .n_wtile_i(n_w), .n_atile_i(n_a),
    .w_ready_i(w_ready), .a_done_i(a_done), .wb_done_i(wb_done),
    .w_load_o(w_load), .a_stream_o(a_stream), .drain_o(drain),
    .wb_o(wb), .done_o(done), .wt_idx_o(wt_idx), .at_idx_o(at_idx)
  );

  int checks = 0, fails = 0, cycles = 0;
  int d_load = 0, d_str = 0, d_wb = 0;
  bit hold_hi = 1'b0;
  bit mon_en = 1'b0;
  string job_tag = "R1";
  logic [IW-1:0] sb_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk(input int code, input int w, input int a);
    return {3'(code), CNT_W'(w), CNT_W'(a)};
  endfunction

  // driver: pushes the expected phase sequence, then pulses start
  task automatic run_job(input int nw, input int na, input string tag);
    job_tag = tag;
    if (nw == 0 || na == 0) sb_q.push_back(mk(C_DONE, 0, 0));
    else begin
      for (int w = 0; w < nw; w++) begin
        sb_q.push_back(mk(C_LOAD, w, 0));
        for (int a = 0; a < na; a++) sb_q.push_back(mk(C_STR, w, a));
        sb_q.push_back(mk(C_DRN, w, na - 1));
        sb_q.push_back(mk(C_WB, w, na - 1));
      end
      sb_q.push_back(mk(C_DONE, nw - 1, 0));
    end
    n_w = CNT_W'(nw);
    n_a = CNT_W'(na);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // responders
  initial begin
    w_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (w_load && rst_n) begin
        repeat (d_load) @(negedge clk);
        w_ready = 1'b1;
        @(negedge clk);
        w_ready = 1'b0;
      end
    end
  end

  initial begin
    a_done = 1'b0;
    forever begin
      @(negedge clk);
      if (hold_hi) a_done = 1'b1;
      else begin
        a_done = 1'b0;
        if (a_stream && rst_n) begin
          repeat (d_str) @(negedge clk);
          a_done = 1'b1;
          @(negedge clk);
          a_done = 1'b0;
        end
      end
    end
  end

  initial begin
    wb_done = 1'b0;
    forever begin
      @(negedge clk);
      if (hold_hi) wb_done = 1'b1;
      else begin
        wb_done = 1'b0;
        if (wb && rst_n) begin
          repeat (d_wb) @(negedge clk);
          wb_done = 1'b1;
          @(negedge clk);
          wb_done = 1'b0;
        end
      end
    end
  end

  // monitor: phase entries against the scoreboard, drain length, done width
  int prev_code = C_IDLE;
  logic [CNT_W-1:0] prev_w = '0, prev_a = '0;
  int drn_len = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      int code, n;
      logic [IW-1:0] exp_i;
      n = int'(w_load) + int'(a_stream) + int'(drain) + int'(wb) + int'(done);
      code = (n > 1) ? C_BAD : w_load ? C_LOAD : a_stream ? C_STR : drain ? C_DRN :
             wb ? C_WB : done ? C_DONE : C_IDLE;
      if (code != C_IDLE && (code != prev_code || wt_idx != prev_w || at_idx != prev_a)) begin
        if (sb_q.size() == 0)
          chk(1'b0, job_tag, "unexpected phase entry, code", code, -1);
        else begin
          exp_i = sb_q.pop_front();
          chk(exp_i == mk(code, wt_idx, at_idx), job_tag, "phase/wt/at packed",
              int'(mk(code, wt_idx, at_idx)), int'(exp_i));
        end
      end
      if (code == C_DRN) drn_len++;
      else if (drn_len != 0) begin
        chk(drn_len == DRAIN_CYC, "R5", "drain length", drn_len, DRAIN_CYC);
        drn_len = 0;
      end
      if (prev_code == C_DONE)  // R7 single-cycle flag
        chk(code == C_IDLE, "R7", "phase after done", code, C_IDLE);
      prev_code = code;
      prev_w = wt_idx;
      prev_a = at_idx;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog: cycles actual=%0d expected<=%0d", cycles, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({w_load, a_stream, drain, wb, done} == 5'b0, "R1", "strobes in reset", int'({w_load, a_stream, drain, wb, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({w_load, a_stream, drain, wb, done} == 5'b0, "R1", "strobes after reset", int'({w_load, a_stream, drain, wb, done}), 0);
    chk(wt_idx == 0 && at_idx == 0, "R1", "indices after reset", int'({wt_idx, at_idx}), 0);
    mon_en = 1'b1;

    // R2 R3 R4 R5 R6 R7 basic jobs with varied handshake delays
    d_load = 1; d_str = 2; d_wb = 1;
    run_job(1, 1, "R2");
    wait_idle();
    d_load = 0; d_str = 0; d_wb = 3;
    run_job(3, 2, "R4");
    wait_idle();
    d_load = 2; d_str = 1; d_wb = 0;
    run_job(2, 3, "R6");
    wait_idle();

    // R4 activation index up to its top value, handshakes held high
    hold_hi = 1'b1; d_load = 0;
    run_job(2, 15, "R4");
    wait_idle();

    // R9 stray handshakes while idle and during a weight load
    repeat (3) @(negedge clk);
    chk({w_load, a_stream, drain, wb, done} == 5'b0, "R9", "strobes with idle handshakes", int'({w_load, a_stream, drain, wb, done}), 0);
    d_load = 6;
    run_job(1, 2, "R9");
    repeat (4) @(negedge clk);
    chk(w_load && at_idx == 0 && wt_idx == 0, "R9", "still loading with foreign handshakes", int'({w_load, wt_idx, at_idx}), 256);
    wait_idle();
    hold_hi = 1'b0;

    // R8 zero counts
    d_load = 1; d_str = 0; d_wb = 0;
    run_job(0, 3, "R8");
    wait_idle();
    run_job(2, 0, "R8");
    wait_idle();

    // R2 start and count changes during a job are ignored
    d_str = 1; d_wb = 2;
    run_job(2, 2, "R2");
    repeat (3) @(negedge clk);
    n_w = 4'd7; n_a = 4'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk({w_load, a_stream, drain, wb, done} == 5'b0, "R7", "idle after done", int'({w_load, a_stream, drain, wb, done}), 0);
    chk(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule